// File: doc/BRIEF.md
# I2C Serial Memory Target Engine

This block is the bus-side engine of a byte-addressed serial memory that holds up to 2048 bytes. It runs on a fast system clock. It samples the two-wire bus lines through synchronizers and a stability filter, and it recognises bus conditions. It decodes and matches the address byte and returns or withholds acknowledge by driving an open-drain enable. It keeps one address pointer, which the read path and the write path share.

Read data comes from a synchronous read port that has a single-cycle latency. The engine fetches each byte ahead of the bit slot that needs it. Received write bytes leave the engine on a valid/ready stream towards a separate page buffer, together with their array address. A one-cycle commit pulse marks the STOP that closes a write transfer. An external busy input shows that the array is programming. While it is high, the engine refuses its own address, so a host can poll for the end of a write cycle.

The address byte always carries the fixed type code 1010 in its upper nibble. Its bits 3..1 are either compared against strap pins or used as high array address bits, depending on the configured density.

Top module: `i2c_mem_target`

## Requirements
- R1: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START at any point, including in the middle of a byte, restarts address reception. A STOP returns the engine to idle with `sda_oe` low.
- R2: The address byte is received MSB first. If bits 7..4 are not 1010, the engine never drives SDA until the next START or STOP. This covers the acknowledge slot of that byte and every byte that follows.
- R3: The density is set by MEM_BYTES. At 256 bytes, address-byte bits 3..1 must equal `dev_pins[2:0]`. At 512 bytes, bits 3..2 must equal pins 2..1 and bit 1 is a8. At 1024 bytes, bit 3 must equal pin 2, and bits 2..1 are a9..a8. At 2048 bytes, no pin is compared, and bits 3..1 are a10..a8.
- R4: On a matching address, `sda_oe` goes high after the SCL fall that ends bit 8. It stays high until the SCL fall that ends the ninth pulse.
- R5: After a write-mode address (bit 0 = 0), the first byte loads the low 8 pointer bits. Every byte of that transfer that is accepted gets an acknowledge.
- R6: Each later write byte appears on `wr_valid`/`wr_addr`/`wr_data`. It is held unchanged until `wr_ready` is high. The write address then advances inside a 16-byte page, so the low 4 bits wrap and the upper bits stay fixed. If a new byte completes while the previous one has not been taken, the engine does not acknowledge it, drops it, and stays silent until the next START or STOP.
- R7: A STOP that ends a transfer in which at least one write byte was taken pulses `wr_commit` for one cycle. A write transfer that carries only the pointer byte gives no pulse.
- R8: A repeated START and then a read-mode address (bit 0 = 1) reads from the pointer loaded by the preceding write-mode transfer.
- R9: A read-mode address with no pointer byte before it reads the byte after the last one accessed. Bits 3..1 of the address byte replace the high pointer bits as in R3.
- R10: Each master acknowledge in a read makes the engine send the next byte. The pointer counts across all array bits and wraps from the top address to 0.
- R11: After a master not-acknowledge, the engine keeps SDA released until the next START or STOP.
- R12: If `busy_i` is high when the address byte completes, the engine does not acknowledge.
- R13: Each fetched byte causes exactly one single-cycle `rd_en` pulse. `rd_data` is taken on the following cycle.
- R14: `sda_oe` changes only after a detected SCL falling edge or a bus condition, never while SCL is high during a data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (wired level) |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| dev_pins | input | 3 | Strap pins compared against address-byte bits 3..1 |
| busy_i | input | 1 | Array programming in progress |
| rd_en | output | 1 | Read strobe to the memory port |
| rd_addr | output | ADDR_W | Read address, which is the current pointer |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Page buffer accepts the byte |
| wr_addr | output | ADDR_W | Array address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse at the STOP that closes a write |

## Verification
Byte writes followed by selective reads run at addresses spread over several array blocks. A wrong block field or a wrong pointer load therefore shows up as a wrong byte read back. A multi-byte write that starts two bytes before a page boundary shows page wrap as distinct from a full increment. A sequential read started two bytes below the top address shows full wrap to 0 as distinct from page wrap. Address bytes with a bad type nibble, a wrong strap value, a high busy input, an interrupting START and a refused byte under back-pressure each separate an acknowledge from a silent slot. Every one of these is told apart at the wired data line.

// File: rtl/i2c_pkg.sv
package i2c_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic s1, s2;
  logic [FILT_LEN-1:0] hist;

  // two-flop synchronizer, then the output follows only a unanimous history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= RST_VAL;
      s2   <= RST_VAL;
      hist <= {FILT_LEN{RST_VAL}};
      dout <= RST_VAL;
    end else begin
      s1   <= din;
      s2   <= s1;
      hist <= {hist[FILT_LEN-2:0], s2};
      if (&hist)       dout <= 1'b1;
      else if (~|hist) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_blk,
  input  logic [2:0]        blk,
  input  logic              ld_lo,
  input  logic [7:0]        lo,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] ptr, with_blk, with_lo, page_nxt;

  generate
    if (ADDR_W > 8) begin : g_wide
      assign with_blk = {blk[ADDR_W-9:0], ptr[7:0]};
      assign with_lo  = {ptr[ADDR_W-1:8], lo};
    end else begin : g_narrow
      assign with_blk = ptr;
      assign with_lo  = lo;
    end
  endgenerate

  assign page_nxt = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (ld_blk)   ptr <= with_blk;
    else if (ld_lo)    ptr <= with_lo;
    else if (inc_page) ptr <= page_nxt;
    else if (inc_full) ptr <= ptr + ADDR_W'(1);
  end

  assign addr = ptr;

  // R10
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !ld_blk && !ld_lo && !inc_page) |=> addr == $past(addr) + ADDR_W'(1));

  // R6
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !ld_blk && !ld_lo) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_pkg::*;
#(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 16,
  parameter int FILT_LEN   = 3,
  localparam int ADDR_W    = $clog2(MEM_BYTES),
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int BLK_W     = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_pins,
  input  logic              busy_i,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
  i2c_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

  i2c_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  tgt_state_t state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic rw, mack, oe;
  logic rd_en_q, rd_pend;
  logic wr_valid_q, wrote, commit_q;
  logic [ADDR_W-1:0] wr_addr_q, ptr;
  logic [7:0] wr_data_q;

  logic byte_done, addr_hit, wr_free;
  logic ld_blk, ld_lo, inc_page, inc_full;
  logic [2:0] pin_ok;

  // bits of the address field that are not array address must match the straps
  always_comb begin
    for (int i = 0; i < 3; i++)
      pin_ok[i] = (i < BLK_W) || (sh[i+1] == dev_pins[i]);
  end

  assign byte_done = scl_fall && (cnt == 4'd8);
  assign addr_hit  = (sh[7:4] == DEV_TYPE) && (&pin_ok) && !busy_i;
  assign wr_free   = !wr_valid_q || wr_ready;

  assign ld_blk   = (state == ST_DEV) && byte_done && addr_hit;
  assign ld_lo    = (state == ST_WADDR) && byte_done;
  assign inc_page = (state == ST_WDATA) && byte_done && wr_free;
  assign inc_full = rd_pend;

  i2c_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_blk(ld_blk), .blk(sh[3:1]),
    .ld_lo(ld_lo), .lo(sh),
    .inc_page(inc_page), .inc_full(inc_full),
    .addr(ptr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      rw         <= 1'b0;
      mack       <= 1'b0;
      oe         <= 1'b0;
      rd_en_q    <= 1'b0;
      rd_pend    <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      wrote      <= 1'b0;
      commit_q   <= 1'b0;
    end else begin
      rd_en_q  <= 1'b0;
      commit_q <= 1'b0;
      rd_pend  <= rd_en_q;
      if (wr_valid_q && wr_ready) wr_valid_q <= 1'b0;
      if (rd_pend) sh <= rd_data;

      if (start_det) begin
        state <= ST_DEV;
        cnt   <= '0;
        oe    <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        cnt   <= '0;
        oe    <= 1'b0;
        if (wrote) begin
          commit_q <= 1'b1;
          wrote    <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end
            if (byte_done) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (addr_hit) begin
                  oe      <= 1'b1;
                  rw      <= sh[0];
                  rd_en_q <= sh[0];
                  state   <= ST_DEV_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else if (state == ST_WADDR) begin
                oe    <= 1'b1;
                state <= ST_WADDR_ACK;
              end else if (wr_free) begin
                oe         <= 1'b1;
                wr_valid_q <= 1'b1;
                wr_addr_q  <= ptr;
                wr_data_q  <= sh;
                wrote      <= 1'b1;
                state      <= ST_WDATA_ACK;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              oe    <= ~sh[7];
              state <= ST_RDATA;
            end else begin
              oe    <= 1'b0;
              state <= ST_WADDR;
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            oe    <= 1'b0;
            state <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall) begin
            if (cnt == 4'd7) begin
              oe    <= 1'b0;
              cnt   <= '0;
              state <= ST_RACK;
            end else begin
              oe  <= ~sh[6];
              sh  <= {sh[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
          ST_RACK: begin
            // prefetch at the acknowledge rise so the byte is ready at the fall
            if (scl_rise) begin
              mack    <= ~sda_f;
              rd_en_q <= ~sda_f;
            end
            if (scl_fall) begin
              if (mack) begin
                oe    <= ~sh[7];
                state <= ST_RDATA;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe;
  assign rd_en     = rd_en_q;
  assign rd_addr   = ptr;
  assign wr_valid  = wr_valid_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign wr_commit = commit_q;

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && state == ST_DEV && cnt == 4'd0));

  // R14
  oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det));

  // R12
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && byte_done && busy_i) |=> !sda_oe);

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  // R13
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV_ACK && !scl_fall && !start_det && !stop_det) |=> sda_oe);
endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0, rdy = 1'b1;
  logic oe_main, oe_small, sda_bus;
  assign sda_bus = sda_m & ~oe_main & ~oe_small;

  logic rd_en, wr_valid, wr_commit;
  logic [10:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  logic s_rd_en, s_wr_valid, s_wr_commit;
  logic [7:0] s_rd_addr, s_wr_addr, s_wr_data;

  i2c_mem_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_main),
    .dev_pins(3'b000), .busy_i(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(rdy), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit));

  i2c_mem_target #(.MEM_BYTES(256)) uut_small (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_small),
    .dev_pins(3'b101), .busy_i(1'b0),
    .rd_en(s_rd_en), .rd_addr(s_rd_addr), .rd_data(8'hA5),
    .wr_valid(s_wr_valid), .wr_ready(1'b1), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
    .wr_commit(s_wr_commit));

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) ^ (i >> 8) ^ 8'h5C);
  endfunction

  logic [7:0]  mem [0:2047];
  logic [10:0] log_addr [0:63];
  logic [7:0]  log_data [0:63];
  int nwr = 0, ncommit = 0, nrd = 0, rd_wide = 0, oe_bad = 0;
  logic rd_prev = 1'b0, oe_prev = 1'b0;

  initial for (int i = 0; i < 2048; i++) mem[i] = pat(i);

  always @(posedge clk) begin
    if (wr_valid && rdy) begin
      mem[wr_addr] <= wr_data;
      log_addr[nwr[5:0]] <= wr_addr;
      log_data[nwr[5:0]] <= wr_data;
      nwr <= nwr + 1;
    end
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_commit) ncommit <= ncommit + 1;
    if (rd_en) nrd <= nrd + 1;
    if (rd_en && rd_prev) rd_wide <= rd_wide + 1;
    if (rst_n && scl_m && oe_main != oe_prev) oe_bad <= oe_bad + 1;
    rd_prev <= rd_en;
    oe_prev <= oe_main;
  end

  int ntests = 0, nfail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic clk_bit(input logic b, output logic om, output logic os, output logic v);
    sda_m = b; hq(); scl_m = 1'b1; hq();
    v = sda_bus; om = oe_main; os = oe_small;
    hq(); scl_m = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic am, output logic as_);
    logic v;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], am, as_, v);
    clk_bit(1'b1, am, as_, v);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic om, os, v;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, om, os, v);
      d = {d[6:0], v};
    end
    clk_bit(~mack, om, os, v);
  endtask

  // table: {array address, data byte}
  localparam logic [18:0] VEC [0:5] = '{
    {11'h012, 8'h3C}, {11'h0FF, 8'hC3}, {11'h2A0, 8'h81},
    {11'h3FF, 8'h7E}, {11'h456, 8'h00}, {11'h6EF, 8'hFF}};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL R1: watchdog got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin : main
    logic a1, a2, a3, s1, s2;
    logic [7:0] d0, d1, d2;
    logic [10:0] a;
    int w0, c0, r0;
    logic om, os, v, allhi;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {28'h0, oe_main, rd_en, wr_valid, wr_commit}, 32'h0);

    for (int k = 0; k < 6; k++) begin
      a = VEC[k][18:8];
      w0 = nwr; c0 = ncommit;
      bus_start();
      send_byte({4'hA, a[10:8], 1'b0}, a1, s1);
      send_byte(a[7:0], a2, s1);
      send_byte(VEC[k][7:0], a3, s1);
      bus_stop();
      repeat (4) @(negedge clk);
      check("R4 R5 byte write acks", {29'h0, a1, a2, a3}, 32'h7);
      check("R6 write stream addr", {21'h0, log_addr[w0[5:0]]}, {21'h0, a});
      check("R6 write stream data", {24'h0, log_data[w0[5:0]]}, {24'h0, VEC[k][7:0]});
      check("R7 commit after write", ncommit - c0, 1);
      bus_start();
      send_byte({4'hA, a[10:8], 1'b0}, a1, s1);
      send_byte(a[7:0], a2, s1);
      bus_start();
      send_byte({4'hA, a[10:8], 1'b1}, a3, s1);
      recv_byte(1'b0, d0);
      bus_stop();
      check("R8 selective read back", {24'h0, d0}, {24'h0, VEC[k][7:0]});
    end

    // R9 immediate read: last access 0x6EF, expect 0x6F0
    bus_start();
    send_byte({4'hA, 3'd6, 1'b1}, a1, s1);
    recv_byte(1'b0, d0);
    bus_stop();
    check("R9 immediate read", {23'h0, a1, d0}, {23'h0, 1'b1, pat(11'h6F0)});

    // R10 sequential read across the top address, R13 fetch count
    bus_start();
    send_byte({4'hA, 3'd7, 1'b0}, a1, s1);
    send_byte(8'hFE, a2, s1);
    r0 = nrd;
    bus_start();
    send_byte({4'hA, 3'd7, 1'b1}, a3, s1);
    recv_byte(1'b1, d0);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    bus_stop();
    check("R10 seq read 7FE", {24'h0, d0}, {24'h0, pat(11'h7FE)});
    check("R10 seq read 7FF", {24'h0, d1}, {24'h0, pat(11'h7FF)});
    check("R10 seq read wraps to 000", {24'h0, d2}, {24'h0, pat(0)});
    check("R13 one rd_en per byte", nrd - r0, 3);

    // R11 master NACK then further clocks: bus stays released
    bus_start();
    send_byte({4'hA, 3'd2, 1'b0}, a1, s1);
    send_byte(8'h00, a2, s1);
    bus_start();
    send_byte({4'hA, 3'd2, 1'b1}, a3, s1);
    recv_byte(1'b0, d0);
    allhi = 1'b1;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, om, os, v);
      allhi = allhi & v;
    end
    bus_stop();
    check("R11 released after NACK", {31'h0, allhi}, 32'h1);

    // R2 bad type nibble: no ack on address nor on following byte
    bus_start();
    send_byte(8'h90, a1, s1);
    send_byte(8'h00, a2, s1);
    bus_stop();
    check("R2 wrong type nibble silent", {30'h0, a1, a2}, 32'h0);

    // R1 START in the middle of a byte restarts address reception
    bus_start();
    clk_bit(1'b1, om, os, v); clk_bit(1'b0, om, os, v);
    clk_bit(1'b1, om, os, v); clk_bit(1'b0, om, os, v);
    bus_start();
    send_byte({4'hA, 3'd0, 1'b0}, a1, s1);
    bus_stop();
    check("R1 mid-byte START restart", {31'h0, a1}, 32'h1);

    // R6 page wrap: 0x10E, 0x10F, then 0x100
    w0 = nwr;
    bus_start();
    send_byte({4'hA, 3'd1, 1'b0}, a1, s1);
    send_byte(8'h0E, a1, s1);
    send_byte(8'h11, a1, s1);
    send_byte(8'h22, a2, s1);
    send_byte(8'h33, a3, s1);
    bus_stop();
    check("R6 page wrap addresses",
          {log_addr[w0[5:0]], log_addr[w0[5:0]+6'd1], log_addr[w0[5:0]+6'd2]},
          {11'h10E, 11'h10F, 11'h100});

    // R6 back-pressure: second byte refused while first is pending
    rdy = 1'b0;
    w0 = nwr; c0 = ncommit;
    bus_start();
    send_byte({4'hA, 3'd3, 1'b0}, a1, s1);
    send_byte(8'h30, a1, s1);
    send_byte(8'h11, a2, s1);
    send_byte(8'h22, a3, s1);
    check("R6 refused byte not acked", {30'h0, a2, a3}, 32'h2);
    check("R6 pending byte held", {22'h0, wr_valid, wr_data, wr_addr[0]}, {22'h0, 1'b1, 8'h11, 1'b0});
    rdy = 1'b1;
    repeat (4) @(negedge clk);
    bus_stop();
    repeat (4) @(negedge clk);
    check("R6 only first byte taken", {nwr - w0, 21'h0, log_addr[w0[5:0]]}, {32'd1, 21'h0, 11'h330} );
    check("R7 commit after refused write", ncommit - c0, 1);

    // R7 pointer-only write gives no commit
    c0 = ncommit;
    bus_start();
    send_byte({4'hA, 3'd0, 1'b0}, a1, s1);
    send_byte(8'h40, a2, s1);
    bus_stop();
    repeat (4) @(negedge clk);
    check("R7 no commit without data", ncommit - c0, 0);

    // R12 busy refuses address, then acks once clear
    busy = 1'b1;
    bus_start();
    send_byte({4'hA, 3'd0, 1'b0}, a1, s1);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte({4'hA, 3'd0, 1'b0}, a2, s1);
    bus_stop();
    check("R12 busy nack then ack", {30'h0, a1, a2}, 32'h1);

    // R3 strap compare at 256 bytes, none at 2048
    bus_start();
    send_byte(8'hAA, a1, s1);
    bus_stop();
    bus_start();
    send_byte(8'hA8, a2, s2);
    bus_stop();
    check("R3 strap match/mismatch small", {30'h0, s1, s2}, 32'h2);
    check("R3 no strap compare large", {30'h0, a1, a2}, 32'h3);

    check("R13 rd_en single cycle", rd_wide, 0);
    check("R14 oe steady while SCL high", oe_bad, 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule